// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block sits in front of a fast static array that has a nonvolatile shadow copy. It decides when the whole array is copied into the shadow (a store) and when it is copied back (a recall). Both transfers move every cell in parallel through a modelled backend. While a transfer runs, the sequencer closes the array to all reads and writes. Out of reset it runs a recall first. A store can be started in three ways: a one-cycle software pulse, a supply-low comparator input, or an external agent pulling a shared active-low request/busy line low.

A write-dirty latch records whether the array changed since the last transfer. A store requested through the line or by the comparator runs only when the latch is set. A software store always runs. When the line falls, reads go on for a grace window of `TDELAY` cycles before the store decision is made. New writes stop as soon as the low level has been sampled. During a store the block pulls the line low itself. After the store, or when the line was pulled low with a clean array, the array stays closed until the line is seen high again. The open-drain line is split into a drive-low output and a sampled input. The board, here the bench, joins them as a wired-AND with any external driver.

Array accesses use a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high, and the matching array enable is raised in that same cycle. `req_ready` may depend on `req_write`, because reads and writes are gated differently. When ready is low the requester holds its request or withdraws it. Nothing is queued.

Top module: `nvshadow_seq`

## Requirements
- R1: After reset is released, `nv_recall_go` pulses for one cycle on the first clock edge. `req_ready` stays low until `nv_done` ends the recall, and then goes high. `nv_store_go` and `nv_recall_go` are never high together.
- R2: An accepted read raises `arr_rd_en` and an accepted write raises `arr_wr_en` in the same cycle. No access is accepted while a store or recall is running.
- R3: A `sw_store` pulse starts a store (`nv_store_go` one cycle) even when the array is clean. `line_drive_low` is high from that cycle through the cycle in which `nv_done` is high, and low in the cycle after.
- R4: While `pwr_low` is high and the block is idle, a store starts when the dirty latch is set and `AUTO_STORE_EN` is 1 (the default). With a clean array no store starts and access stays open.
- R5: After the line falls, writes are refused from the cycle in which the sampled level (`SYNC_STAGES` flops) is low. Reads are still accepted until the grace window ends.
- R6: With a dirty array, `nv_store_go` rises on clock edge `SYNC_STAGES + 1 + TDELAY`, counted from the first edge that sees the line low.
- R7: If the line is pulled low externally with a clean array, no store starts and `line_drive_low` stays low. After the grace window all access is refused until the sampled line is high again.
- R8: After a store completes, all access is refused until the sampled line is high. If an external agent keeps the line low, the array stays closed.
- R9: The dirty latch is set by any accepted write and cleared when a store or recall completes. A comparator-driven store that repeats with no write in between is skipped.
- R10: A `sw_store` pulse that arrives while a store is running is ignored and does not cause a second store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Array access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request accepted this cycle when high together with valid |
| arr_rd_en | output | 1 | Array read enable |
| arr_wr_en | output | 1 | Array write enable |
| sw_store | input | 1 | Software store pulse |
| pwr_low | input | 1 | Supply below switch threshold |
| line_in_n | input | 1 | Resolved level of the shared request/busy line |
| line_drive_low | output | 1 | Pull the shared line low |
| nv_store_go | output | 1 | One-cycle store start to backend |
| nv_recall_go | output | 1 | One-cycle recall start to backend |
| nv_done | input | 1 | Backend completion pulse |

## Verification
Stores are started from a clean array and from a dirty array, through each of the three triggers. This shows which trigger honours the dirty latch and which one ignores it. The external line is pulled low in two variants: with a clean array, to show the closed-without-store path, and with a dirty array held low across the whole store, to measure the grace length and show that release depends on the external agent. Read and write attempts are placed inside the grace window to show the two different gating rules. A software pulse is sent mid-store and a comparator store is repeated, to show that neither causes a second transfer.

// File: rtl/nvshadow_pkg.sv
package nvshadow_pkg;

  typedef enum logic [2:0] {
    SQ_RECALL,
    SQ_IDLE,
    SQ_GRACE,
    SQ_STORE,
    SQ_HOLD,
    SQ_EXT_HOLD
  } sq_state_e;

  function automatic logic sq_in_xfer(input sq_state_e s);
    return (s == SQ_STORE) || (s == SQ_RECALL);
  endfunction

endpackage

// File: rtl/nvshadow_line_sync.sv
module nvshadow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in_n,
  output logic line_q
);

  generate
    if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b1;
        else        s_q <= line_in_n;
      end
      assign line_q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], line_in_n};
      end
      assign line_q = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/nvshadow_dirty.sv
module nvshadow_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic xfer_done,
  output logic dirty
);

  logic dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dirty_q <= 1'b0;
    else if (wr_hit)    dirty_q <= 1'b1;
    else if (xfer_done) dirty_q <= 1'b0;
  end

  assign dirty = dirty_q;

  assert_dirty_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> dirty);
  assert_dirty_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr_hit) |=> !dirty);

endmodule

// File: rtl/nvshadow_grace.sv
module nvshadow_grace #(
  parameter int TDELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CW = (TDELAY < 2) ? 1 : $clog2(TDELAY + 1);
  localparam logic [CW-1:0] START = CW'(TDELAY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= START;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  assert_grace_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == START));

endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl
  import nvshadow_pkg::*;
#(
  parameter bit AUTO_STORE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_write,
  input  logic sw_store,
  input  logic pwr_low,
  input  logic line_q,
  input  logic dirty,
  input  logic grace_expired,
  input  logic nv_done,
  output logic grace_load,
  output logic req_ready,
  output logic drive_low,
  output logic store_go,
  output logic recall_go,
  output logic xfer_done
);

  sq_state_e state_q, state_n;
  logic      started_q, rec_go_q, st_go_q;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      SQ_RECALL:   if (nv_done) state_n = SQ_IDLE;
      SQ_IDLE: begin
        if (sw_store)                              state_n = SQ_STORE;
        else if (pwr_low && AUTO_STORE_EN && dirty) state_n = SQ_STORE;
        else if (!line_q)                          state_n = SQ_GRACE;
      end
      SQ_GRACE:    if (grace_expired) state_n = dirty ? SQ_STORE : SQ_EXT_HOLD;
      SQ_STORE:    if (nv_done) state_n = SQ_HOLD;
      SQ_HOLD:     if (line_q) state_n = SQ_IDLE;
      SQ_EXT_HOLD: if (line_q) state_n = SQ_IDLE;
      default:     state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_RECALL;
      started_q <= 1'b0;
      rec_go_q  <= 1'b0;
      st_go_q   <= 1'b0;
    end else begin
      state_q   <= state_n;
      started_q <= 1'b1;
      rec_go_q  <= !started_q;
      st_go_q   <= (state_n == SQ_STORE) && (state_q != SQ_STORE);
    end
  end

  assign grace_load = (state_q == SQ_IDLE) && (state_n == SQ_GRACE);
  assign drive_low  = (state_q == SQ_STORE);
  assign store_go   = st_go_q;
  assign recall_go  = rec_go_q;
  assign xfer_done  = nv_done && sq_in_xfer(state_q);

  always_comb begin
    unique case (state_q)
      SQ_IDLE:  req_ready = line_q || !req_write;
      SQ_GRACE: req_ready = !req_write;
      default:  req_ready = 1'b0;
    endcase
  end

  assert_closed_in_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_go || recall_go) |-> !req_ready);
  assert_recall_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    recall_go |=> !recall_go);
  assert_hold_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HOLD && !line_q) |-> !req_ready);

endmodule

// File: rtl/nvshadow_seq.sv
module nvshadow_seq
  import nvshadow_pkg::*;
#(
  parameter int TDELAY        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter bit AUTO_STORE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic arr_rd_en,
  output logic arr_wr_en,
  input  logic sw_store,
  input  logic pwr_low,
  input  logic line_in_n,
  output logic line_drive_low,
  output logic nv_store_go,
  output logic nv_recall_go,
  input  logic nv_done
);

  logic line_q, dirty, grace_load, grace_expired, xfer_done;

  nvshadow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in_n(line_in_n), .line_q(line_q)
  );

  nvshadow_dirty u_dirty (
    .clk(clk), .rst_n(rst_n), .wr_hit(arr_wr_en), .xfer_done(xfer_done),
    .dirty(dirty)
  );

  nvshadow_grace #(.TDELAY(TDELAY)) u_grace (
    .clk(clk), .rst_n(rst_n), .load(grace_load), .expired(grace_expired)
  );

  nvshadow_ctrl #(.AUTO_STORE_EN(AUTO_STORE_EN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_write(req_write), .sw_store(sw_store),
    .pwr_low(pwr_low), .line_q(line_q), .dirty(dirty),
    .grace_expired(grace_expired), .nv_done(nv_done),
    .grace_load(grace_load), .req_ready(req_ready),
    .drive_low(line_drive_low), .store_go(nv_store_go),
    .recall_go(nv_recall_go), .xfer_done(xfer_done)
  );

  assign arr_rd_en = req_valid && req_ready && !req_write;
  assign arr_wr_en = req_valid && req_ready && req_write;

  assert_go_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_store_go && nv_recall_go));
  assert_no_access_on_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nv_store_go |-> (!arr_rd_en && !arr_wr_en));
  assert_drive_on_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nv_store_go |-> line_drive_low);
  assert_release_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_drive_low && nv_done) |=> !line_drive_low);
  assert_write_blocked_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !line_q |-> !arr_wr_en);

endmodule

// File: tb/nvshadow_seq_test.sv
module nvshadow_seq_test;

  localparam int TD   = 6;
  localparam int SYN  = 2;
  localparam int LAT  = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, sw_store = 0, pwr_low = 0, nv_done = 0;
  logic ext_low = 0;
  logic req_ready, arr_rd_en, arr_wr_en, line_drive_low, nv_store_go, nv_recall_go;
  logic line_n;

  int checks = 0, errors = 0, cyc = 0;
  byte expq[$];

  assign line_n = !(line_drive_low || ext_low);

  nvshadow_seq #(.TDELAY(TD), .SYNC_STAGES(SYN), .AUTO_STORE_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en),
    .sw_store(sw_store), .pwr_low(pwr_low), .line_in_n(line_n),
    .line_drive_low(line_drive_low), .nv_store_go(nv_store_go),
    .nv_recall_go(nv_recall_go), .nv_done(nv_done)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk); #2;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // backend model
  initial forever begin
    @(negedge clk);
    if (nv_store_go || nv_recall_go) begin
      repeat (LAT - 1) @(negedge clk);
      nv_done = 1;
      @(negedge clk);
      nv_done = 0;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && (nv_store_go || nv_recall_go)) begin
      byte got, exp;
      got = nv_store_go ? "S" : "R";
      if (expq.size() == 0) chk(0, "R1/R9/R10 unexpected transfer", got, 0);
      else begin
        exp = expq.pop_front();
        chk(got == exp, "R1/R4 transfer kind", got, exp);
      end
    end
  end

  // watchdog
  initial forever begin
    @(negedge clk);
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  task automatic wait_open(input string tag, input int lim);
    int n = 0;
    req_write = 0;
    while (!req_ready && n < lim) begin tick(); n++; end
    chk(req_ready, tag, req_ready, 1);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!nv_done && n < 200) begin tick(); n++; end
  endtask

  task automatic do_write;
    req_valid = 1; req_write = 1; #1;
    chk(arr_wr_en == 1, "R2 write accepted", arr_wr_en, 1);
    tick(); req_valid = 0; req_write = 0;
  endtask

  initial begin
    int n;
    expq.push_back("R");
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(req_ready == 0, "R1 closed during recall", req_ready, 0);
    wait_open("R1 open after recall", LAT + 4);

    // R2 read
    req_valid = 1; req_write = 0; #1;
    chk(arr_rd_en == 1 && arr_wr_en == 0, "R2 read accepted", arr_rd_en, 1);
    tick(); req_valid = 0;

    // R4 clean power-fail: skipped
    pwr_low = 1;
    repeat (6) tick();
    chk(line_drive_low == 0, "R4 clean pwr_low no drive", line_drive_low, 0);
    chk(req_ready == 1, "R4 clean pwr_low stays open", req_ready, 1);
    pwr_low = 0; tick();

    // R3 software store on clean array, R10 mid-store pulse ignored
    expq.push_back("S");
    sw_store = 1; tick(); sw_store = 0;
    chk(line_drive_low == 1, "R3 drive low at store", line_drive_low, 1);
    chk(req_ready == 0, "R2 closed during store", req_ready, 0);
    repeat (3) tick();
    sw_store = 1; tick(); sw_store = 0;
    wait_done(n);
    chk(line_drive_low == 1, "R3 drive held through done", line_drive_low, 1);
    tick();
    chk(line_drive_low == 0, "R3 release after done", line_drive_low, 0);
    chk(req_ready == 0, "R8 closed until line seen high", req_ready, 0);
    wait_open("R8 open after line high", SYN + 4);
    repeat (LAT + 4) tick();

    // R4 dirty power-fail store, R9 repeat skipped
    do_write();
    expq.push_back("S");
    pwr_low = 1;
    wait_done(n);
    chk(n < LAT + 6, "R4 dirty pwr_low store ran", n, LAT);
    wait_open("R8 open after pwr store", SYN + 4);
    repeat (LAT + 6) tick();
    chk(line_drive_low == 0, "R9 repeat pwr_low skipped", line_drive_low, 0);
    pwr_low = 0; tick();

    // R5/R7 external low with clean array
    ext_low = 1;
    tick(); tick();
    req_write = 1; #1;
    chk(req_ready == 0, "R5 write refused after sample", req_ready, 1'b0);
    req_write = 0; #1;
    chk(req_ready == 1, "R5 read allowed in grace", req_ready, 1);
    repeat (TD) tick();
    chk(req_ready == 1, "R5 read allowed end of grace", req_ready, 1);
    tick(); tick();
    chk(req_ready == 0, "R7 closed after clean grace", req_ready, 0);
    chk(line_drive_low == 0, "R7 no self drive", line_drive_low, 0);
    repeat (5) tick();
    chk(req_ready == 0, "R7 stays closed while held", req_ready, 0);
    ext_low = 0;
    wait_open("R7 open after release", SYN + 4);

    // R6 grace length with dirty array, R8 external hold after store
    do_write();
    expq.push_back("S");
    ext_low = 1;
    n = 0;
    while (!nv_store_go && n < 100) begin tick(); n++; end
    chk(n == SYN + 1 + TD, "R6 store start edge", n, SYN + 1 + TD);
    wait_done(n);
    repeat (6) tick();
    chk(req_ready == 0, "R8 closed while external holds", req_ready, 0);
    chk(line_drive_low == 0, "R8 own drive released", line_drive_low, 0);
    ext_low = 0;
    wait_open("R8 open after external release", SYN + 4);

    repeat (LAT + 4) tick();
    chk(expq.size() == 0, "R1/R3/R4/R6 all expected transfers seen", expq.size(), 0);
    finish_run();
  end

endmodule